// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a minimal processor whose entire instruction set is a single operation. Each instruction fills three consecutive memory words: the address of a destination operand, the address of a source operand and a branch target. The processor subtracts the source word from the destination word and stores the difference back into the destination. If the difference is negative, control moves to the target. Otherwise the next instruction in sequence runs. Clearing a word, moving a value and building counted loops are all written as short sequences of this one instruction.

The processor uses one single-port synchronous memory for both code and data. It works through each instruction with a seven-state controller that makes at most one access per state. Three states fetch the instruction fields. Two states read the operands. One state writes the result, and one state chooses the next program counter without touching memory. A taken branch to the instruction's own address acts as a halt. The processor then raises `halted_o` and makes no more memory requests. Reset loads the program counter from `start_addr_i`.

Top module: `sbn_core`

## Requirements
- R1: While `rst_ni` is low, `halted_o` is 0 and the block requests a read (`mem_re_o`=1) at address `start_addr_i`. After release, the first instruction is fetched from that address.
- R2: For an instruction at word address P, the block makes five reads in this order: P, P+1, P+2, then the destination address read at P, then the source address read at P+1.
- R3: The sixth access of each instruction is a write (`mem_we_o`=1) to the destination address. The write data is the destination word minus the source word, modulo 2^32.
- R4: If bit 31 of the difference is 1, the next instruction is fetched from the target word read at P+2. Otherwise it is fetched from P+3.
- R5: An instruction whose destination and source addresses are equal writes 0 and falls through to P+3.
- R6: A taken branch whose target equals P raises `halted_o` two cycles after the cycle of its write. From then on `halted_o` stays 1, and `mem_re_o` and `mem_we_o` stay 0 until reset.
- R7: `mem_re_o` and `mem_we_o` are never high in the same cycle. The cycle after each write makes no access, so an instruction takes seven cycles.
- R8: Overflow has no effect on control flow. For example, 0x80000000 minus 1 gives 0x7FFFFFFF, which is not negative, so the instruction falls through.
- R9: Four instructions copy one word to another through a temporary word: clear the destination, clear the temporary, subtract the source from the temporary, then subtract the temporary from the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_addr_i | input | 32 | Word address of the first instruction |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe; read data returns on the next cycle |
| mem_rdata_i | input | 32 | Memory read data |
| halted_o | output | 1 | Processor has stopped |

## Verification
In the write cycle, the result store and the branch decision both come from the same difference. The last instruction of a program therefore stores its result and triggers the halt together. Each test program ends with a self-targeting instruction that writes a negative result. One program contains a taken branch whose target is the sequential address. Another contains a negative result that exits a loop. The scoreboard checks the final write against an independent interpreter, and the bench measures the exact distance in cycles from that write to the rise of `halted_o`. It then confirms that no further memory access appears.

// File: rtl/sbn_pkg.sv
package sbn_pkg;
  localparam int unsigned INSN_WORDS = 3;

  typedef enum logic [2:0] {
    ST_FD   = 3'd0,
    ST_FS   = 3'd1,
    ST_FT   = 3'd2,
    ST_RD   = 3'd3,
    ST_RS   = 3'd4,
    ST_WR   = 3'd5,
    ST_UPD  = 3'd6,
    ST_HALT = 3'd7
  } sbn_state_e;
endpackage

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
  import sbn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  output sbn_state_e state_o
);
  sbn_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FD:   state_d = ST_FS;
      ST_FS:   state_d = ST_FT;
      ST_FT:   state_d = ST_RD;
      ST_RD:   state_d = ST_RS;
      ST_RS:   state_d = ST_WR;
      ST_WR:   state_d = ST_UPD;
      ST_UPD:  state_d = halt_i ? ST_HALT : ST_FD;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FD;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sbn_sub.sv
module sbn_sub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] minuend_i,
  input  logic [DW-1:0] subtrahend_i,
  output logic [DW-1:0] diff_o,
  output logic          neg_o
);
  // wraps modulo 2^DW; overflow deliberately not flagged
  assign diff_o = minuend_i - subtrahend_i;
  assign neg_o  = diff_o[DW-1];
endmodule

// File: rtl/sbn_pc.sv
module sbn_pc
  import sbn_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] start_i,
  input  logic          upd_i,
  input  logic          take_i,
  input  logic [DW-1:0] tgt_i,
  output logic [DW-1:0] pc_o,
  output logic          halt_o
);
  localparam logic [DW-1:0] STRIDE = DW'(INSN_WORDS);

  logic [DW-1:0] pc_q;

  assign halt_o = upd_i && take_i && (tgt_i == pc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= start_i;
    else if (upd_i && !halt_o)  pc_q <= take_i ? tgt_i : pc_q + STRIDE;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] start_addr_i,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);
  sbn_state_e    state;
  logic [DW-1:0] pc;
  logic          halt_req;
  logic [DW-1:0] dst_addr_q, src_addr_q, tgt_q, dst_val_q;
  logic          neg_q;
  logic [DW-1:0] diff;
  logic          neg;

  sbn_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .halt_i  (halt_req),
    .state_o (state)
  );

  sbn_sub #(.DW(DW)) u_sub (
    .minuend_i    (dst_val_q),
    .subtrahend_i (mem_rdata_i),
    .diff_o       (diff),
    .neg_o        (neg)
  );

  sbn_pc #(.DW(DW)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_addr_i),
    .upd_i   (state == ST_UPD),
    .take_i  (neg_q),
    .tgt_i   (tgt_q),
    .pc_o    (pc),
    .halt_o  (halt_req)
  );

  // one access per state; read data lands one state later
  always_comb begin
    mem_addr_o = '0;
    mem_re_o   = 1'b0;
    mem_we_o   = 1'b0;
    unique case (state)
      ST_FD: begin mem_addr_o = pc;            mem_re_o = 1'b1; end
      ST_FS: begin mem_addr_o = pc + DW'(1);   mem_re_o = 1'b1; end
      ST_FT: begin mem_addr_o = pc + DW'(2);   mem_re_o = 1'b1; end
      ST_RD: begin mem_addr_o = dst_addr_q;    mem_re_o = 1'b1; end
      ST_RS: begin mem_addr_o = src_addr_q;    mem_re_o = 1'b1; end
      ST_WR: begin mem_addr_o = dst_addr_q;    mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign mem_wdata_o = diff;
  assign halted_o    = (state == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_addr_q <= '0;
      src_addr_q <= '0;
      tgt_q      <= '0;
      dst_val_q  <= '0;
      neg_q      <= 1'b0;
    end else begin
      unique case (state)
        ST_FS: dst_addr_q <= mem_rdata_i;
        ST_FT: src_addr_q <= mem_rdata_i;
        ST_RD: tgt_q      <= mem_rdata_i;
        ST_RS: dst_val_q  <= mem_rdata_i;
        ST_WR: neg_q      <= neg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbn_core_chk.sv
module sbn_core_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          halted_o
);
  assert_one_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_idle_after_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (!mem_re_o && !mem_we_o));

  assert_wb_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == $past(mem_addr_o, 2)));

  assert_wb_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == $past(mem_rdata_i) - mem_rdata_i));

  assert_halt_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_re_o && !mem_we_o));

  assert_halt_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_after_wb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(mem_we_o, 2));
endmodule

bind sbn_core sbn_core_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_rdata_i (mem_rdata_i),
  .halted_o    (halted_o)
);

// File: tb/tb_sbn_core.sv
`timescale 1ns/1ps
module tb_sbn_core;
  localparam int DW = 32;
  localparam int MW = 128;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] start_addr;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic          mem_we, mem_re, halted;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_we_cyc = 0;
  logic prev_we = 1'b0;

  typedef struct {logic we; logic [DW-1:0] addr; logic [DW-1:0] data;} acc_t;
  acc_t exp_q[$];

  logic [DW-1:0] mem [0:MW-1];
  logic [DW-1:0] ref_mem [0:MW-1];

  always #4 clk = ~clk;

  sbn_core #(.DW(DW)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_addr_i (start_addr),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_we_o     (mem_we),
    .mem_re_o     (mem_re),
    .mem_rdata_i  (mem_rdata),
    .halted_o     (halted)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re || mem_we) begin
      mem_rdata <= mem[mem_addr[6:0]];
      if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every memory access
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_we) check(!(mem_re || mem_we), "R7 access in cycle after write", {31'd0, mem_re | mem_we}, 0);
      if (mem_re && mem_we) check(1'b0, "R7 read and write together", 1, 0);
      if (mem_re || mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected access", mem_addr, 0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          check(mem_we == e.we, "R2 R3 access kind", {31'd0, mem_we}, {31'd0, e.we});
          check(mem_addr == e.addr, "R2 R3 access address", mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.data, "R3 write data", mem_wdata, e.data);
        end
      end
      if (mem_we) last_we_cyc = cyc;
      prev_we = mem_we;
    end else begin
      prev_we = 1'b0;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) mem[i] = '0;
  endtask

  task automatic put_insn(input int p, input int d, input int s, input int t);
    mem[p] = DW'(d); mem[p+1] = DW'(s); mem[p+2] = DW'(t);
  endtask

  // driver: interpret program independently and queue expected accesses
  task automatic drive(input int start, input string tag);
    logic [DW-1:0] pc, d, s, t, r;
    bit done;
    int waited;
    bit seen;
    for (int i = 0; i < MW; i++) ref_mem[i] = mem[i];
    exp_q.delete();
    pc = DW'(start);
    done = 0;
    for (int k = 0; k < 200 && !done; k++) begin
      d = ref_mem[pc[6:0]]; s = ref_mem[pc[6:0]+7'd1]; t = ref_mem[pc[6:0]+7'd2];
      r = ref_mem[d[6:0]] - ref_mem[s[6:0]];
      exp_q.push_back('{1'b0, pc, '0});
      exp_q.push_back('{1'b0, pc + 1, '0});
      exp_q.push_back('{1'b0, pc + 2, '0});
      exp_q.push_back('{1'b0, d, '0});
      exp_q.push_back('{1'b0, s, '0});
      exp_q.push_back('{1'b1, d, r});
      ref_mem[d[6:0]] = r;
      if (r[DW-1]) begin
        if (t == pc) done = 1;
        else pc = t;
      end else begin
        pc = pc + 3;
      end
    end
    start_addr = DW'(start);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(halted == 1'b0, "R1 halted in reset", {31'd0, halted}, 0);
    check(mem_re && !mem_we && mem_addr == DW'(start), "R1 first fetch address", mem_addr, DW'(start));
    rst_ni = 1'b1;
    seen = 0;
    waited = 0;
    while (!seen && waited < 4000) begin
      @(negedge clk);
      waited++;
      if (halted) seen = 1;
    end
    check(seen, {tag, " R6 halt reached"}, {31'd0, seen}, 1);
    if (seen) check(cyc - last_we_cyc == 2, "R6 halt delay after write", DW'(cyc - last_we_cyc), 2);
    repeat (6) @(negedge clk);
    check(halted == 1'b1, "R6 halt sticky", {31'd0, halted}, 1);
    check(exp_q.size() == 0, {tag, " R2 accesses left over"}, DW'(exp_q.size()), 0);
    for (int i = 0; i < MW; i++)
      check(mem[i] === ref_mem[i], {tag, " final memory"}, mem[i], ref_mem[i]);
  endtask

  initial begin : watchdog
    #1500000;
    check(1'b0, "R6 watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mem_rdata = '0;
    start_addr = '0;
    // P1: clear (R5), taken branch (R4), self halt (R6)
    clear_mem();
    put_insn(0, 70, 70, 99);
    put_insn(3, 71, 72, 30);
    put_insn(6, 73, 74, 6);
    put_insn(30, 74, 75, 30);
    mem[70] = 5; mem[71] = 10; mem[72] = 25; mem[75] = 1;
    drive(0, "R4 R5");
    check(mem[70] == 0, "R5 cleared word", mem[70], 0);
    check(mem[71] == 32'hFFFF_FFF1, "R4 negative result", mem[71], 32'hFFFF_FFF1);
    check(mem[73] == 0, "R4 skipped instruction left memory alone", mem[73], 0);

    // P2: move through temp (R9), overflow ignored (R8)
    clear_mem();
    put_insn(12, 81, 81, 15);
    put_insn(15, 82, 82, 18);
    put_insn(18, 82, 80, 21);
    put_insn(21, 81, 82, 24);
    put_insn(24, 83, 84, 50);
    put_insn(27, 85, 86, 27);
    put_insn(50, 87, 87, 50);
    mem[80] = 1234; mem[81] = 777; mem[82] = 55;
    mem[83] = 32'h8000_0000; mem[84] = 1; mem[86] = 1; mem[87] = 9;
    drive(12, "R8 R9");
    check(mem[81] == 1234, "R9 moved value", mem[81], 1234);
    check(mem[83] == 32'h7FFF_FFFF, "R8 wrapped difference", mem[83], 32'h7FFF_FFFF);
    check(mem[87] == 9, "R8 branch not taken on overflow", mem[87], 9);

    // P3: counted loop, exit on negative
    clear_mem();
    put_insn(40, 90, 91, 46);
    put_insn(43, 92, 91, 40);
    put_insn(46, 92, 91, 46);
    mem[90] = 3; mem[91] = 1;
    drive(40, "R4 loop");
    check(mem[90] == 32'hFFFF_FFFF, "R4 loop counter", mem[90], 32'hFFFF_FFFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule